// File: doc/BRIEF.md
# Issue-Bound Operand Shelving Buffer

This block parks decoded instructions for one execution unit until their source registers hold final values, then releases them one at a time. Dispatch writes an instruction into a free slot with no dependency check. A slot keeps only the opcode, the destination register number and the two source register numbers. It keeps no operand data.

A scoreboard holds one valid bit per architectural register and decides readiness. Operand values come from the block's own register file, and they are read only at the moment an entry issues. The execution unit returns a destination number and a result on the write-back port. The result is written into the register file, and the matching valid bit is set.

Dispatch clears the valid bit of the new destination, so younger readers wait for it. A write-back arriving in the cycle it is needed is forwarded both into the readiness test and into the operand read. With no renaming in front of the buffer, write-after-read and write-after-write hazards are avoided by holding dispatch back.

Top module: `issue_shelf`

## Requirements
- R1: When `disp_valid` is high, `full` is low and `conflict` is low, the instruction is stored at that clock edge. If it is ready, it appears on the issue port in the following cycle.
- R2: A source whose use flag is low, or that names register 0, is always ready and is delivered as operand value 0.
- R3: An entry issues only when both of its sources are ready. A source is ready when its register was valid at dispatch or has been written back since.
- R4: While `iss_valid` is high, `iss_op` and `iss_dst` carry the selected entry's opcode and destination. `iss_opa` and `iss_opb` carry the register-file values of its sources as read in that same cycle.
- R5: A write-back with a nonzero `wb_dst` stores `wb_data` into that register and marks it valid. A write-back to register 0 has no effect, and register 0 always reads as 0.
- R6: An accepted dispatch with a nonzero destination marks that register not valid. The clear takes priority over a write-back to the same register in the same cycle. Later readers of that register wait for its write-back.
- R7: At most one entry issues per cycle. Among the ready entries, the one dispatched earliest issues. The issued entry leaves the buffer at the end of that cycle.
- R8: `full` is high exactly when all 4 slots are occupied. A dispatch offered while `full` is high is dropped and never issues.
- R9: A write-back to a register that a waiting entry needs lets that entry issue in the same cycle, with `wb_data` on the corresponding operand.
- R10: `conflict` is high when `disp_valid` is high and `disp_dst` is nonzero and either (a) a shelved entry reads that register, or (b) the register is not valid and is not being written back in that cycle. A dispatch offered with `conflict` high is dropped.
- R11: An instruction that reads its own destination register, with that register valid at dispatch, is ready and issues with the old register value.
- R12: After reset every register reads 0 and is valid, the buffer is empty, and `iss_valid`, `full` and `conflict` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OPW | Opcode of dispatched instruction |
| disp_dst | input | log2(NREG) | Destination register |
| disp_src1 | input | log2(NREG) | First source register |
| disp_use1 | input | 1 | First source is used |
| disp_src2 | input | log2(NREG) | Second source register |
| disp_use2 | input | 1 | Second source is used |
| full | output | 1 | All slots occupied; dispatch dropped |
| conflict | output | 1 | Register hazard; dispatch dropped |
| wb_valid | input | 1 | Result returning from execution unit |
| wb_dst | input | log2(NREG) | Register being written back |
| wb_data | input | DW | Result value |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_op | output | OPW | Opcode of issued entry |
| iss_dst | output | log2(NREG) | Destination of issued entry |
| iss_opa | output | DW | First operand value |
| iss_opb | output | DW | Second operand value |

## Verification
`full`, `conflict` and every issue-port output are combinational in the current buffer contents and the current write-back. They are therefore due in the same cycle as the write-back that enables them (R9, R10), and one cycle after the dispatch that stores the entry (R1). The bench drives inputs on the falling edge and compares 1 ns before the next rising edge. It does so against a reference model whose state advances only on rising edges. An effect that takes a cycle, such as a dispatch clearing a valid bit or an entry leaving after issue, is therefore first seen in the following cycle's comparison. Dropped dispatches are confirmed by the issue stream: the bench checks that they never appear on it.

// File: rtl/issue_shelf.sv
module issue_shelf #(
  parameter int DEPTH = 4,
  parameter int NREG  = 16,
  parameter int OPW   = 4,
  parameter int DW    = 16,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic [OPW-1:0] disp_op,
  input  logic [RW-1:0] disp_dst,
  input  logic [RW-1:0] disp_src1,
  input  logic          disp_use1,
  input  logic [RW-1:0] disp_src2,
  input  logic          disp_use2,
  output logic          full,
  output logic          conflict,
  input  logic          wb_valid,
  input  logic [RW-1:0] wb_dst,
  input  logic [DW-1:0] wb_data,
  output logic          iss_valid,
  output logic [OPW-1:0] iss_op,
  output logic [RW-1:0] iss_dst,
  output logic [DW-1:0] iss_opa,
  output logic [DW-1:0] iss_opb
);

  logic [DEPTH-1:0] e_vld, e_r1, e_r2, rdy;
  logic [OPW-1:0]   e_op  [DEPTH];
  logic [RW-1:0]    e_dst [DEPTH];
  logic [RW-1:0]    e_s1  [DEPTH];
  logic [RW-1:0]    e_s2  [DEPTH];
  logic [DW-1:0]    rf    [NREG];
  logic [NREG-1:0]  rvalid;
  logic [IW-1:0]    sel;
  logic [IW:0]      src_idx [DEPTH];
  logic [CW-1:0]    cnt, wslot;
  logic             readhit, accept, n_r1, n_r2;
  logic [RW-1:0]    n_s1, n_s2, s_a, s_b;

  function automatic logic wbm(input logic v, input logic [RW-1:0] d, input logic [RW-1:0] s);
    return v && (d == s) && (s != '0);
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      rdy[i] = e_vld[i] && (e_r1[i] || wbm(wb_valid, wb_dst, e_s1[i]))
                        && (e_r2[i] || wbm(wb_valid, wb_dst, e_s2[i]));
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (rdy[i]) sel = IW'(i);
  end

  assign iss_valid = |rdy;
  assign iss_op    = e_op[sel];
  assign iss_dst   = e_dst[sel];
  assign s_a       = e_s1[sel];
  assign s_b       = e_s2[sel];

  always_comb begin
    if (s_a == '0) iss_opa = '0;
    else if (wbm(wb_valid, wb_dst, s_a)) iss_opa = wb_data;
    else iss_opa = rf[s_a];
    if (s_b == '0) iss_opb = '0;
    else if (wbm(wb_valid, wb_dst, s_b)) iss_opb = wb_data;
    else iss_opb = rf[s_b];
  end

  always_comb begin
    cnt = '0;
    readhit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt = cnt + CW'(e_vld[i]);
      if (e_vld[i] && (e_s1[i] == disp_dst || e_s2[i] == disp_dst)) readhit = 1'b1;
      src_idx[i] = (IW+1)'(i) + {{IW{1'b0}}, iss_valid && ((IW+1)'(i) >= {1'b0, sel})};
    end
  end

  assign full     = e_vld[DEPTH-1];
  assign conflict = disp_valid && (disp_dst != '0) &&
                    (readhit || (!rvalid[disp_dst] && !wbm(wb_valid, wb_dst, disp_dst)));
  assign accept   = disp_valid && !full && !conflict;
  assign wslot    = cnt - CW'(iss_valid);
  assign n_s1     = disp_use1 ? disp_src1 : '0;
  assign n_s2     = disp_use2 ? disp_src2 : '0;
  assign n_r1     = (n_s1 == '0) || rvalid[n_s1] || wbm(wb_valid, wb_dst, n_s1);
  assign n_r2     = (n_s2 == '0) || rvalid[n_s2] || wbm(wb_valid, wb_dst, n_s2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
      e_r1  <= '0;
      e_r2  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_op[i]  <= '0;
        e_dst[i] <= '0;
        e_s1[i]  <= '0;
        e_s2[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (accept && CW'(i) == wslot) begin
          e_vld[i] <= 1'b1;
          e_op[i]  <= disp_op;
          e_dst[i] <= disp_dst;
          e_s1[i]  <= n_s1;
          e_s2[i]  <= n_s2;
          e_r1[i]  <= n_r1;
          e_r2[i]  <= n_r2;
        end else if (src_idx[i] < (IW+1)'(DEPTH)) begin
          e_vld[i] <= e_vld[src_idx[i][IW-1:0]];
          e_op[i]  <= e_op[src_idx[i][IW-1:0]];
          e_dst[i] <= e_dst[src_idx[i][IW-1:0]];
          e_s1[i]  <= e_s1[src_idx[i][IW-1:0]];
          e_s2[i]  <= e_s2[src_idx[i][IW-1:0]];
          e_r1[i]  <= e_r1[src_idx[i][IW-1:0]] | wbm(wb_valid, wb_dst, e_s1[src_idx[i][IW-1:0]]);
          e_r2[i]  <= e_r2[src_idx[i][IW-1:0]] | wbm(wb_valid, wb_dst, e_s2[src_idx[i][IW-1:0]]);
        end else begin
          e_vld[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= '1;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (wb_valid && wb_dst != '0) begin
        rf[wb_dst]     <= wb_data;
        rvalid[wb_dst] <= 1'b1;
      end
      if (accept && disp_dst != '0) rvalid[disp_dst] <= 1'b0;
    end
  end

endmodule

// File: rtl/issue_shelf_chk.sv
module issue_shelf_chk #(
  parameter int DEPTH = 4,
  parameter int NREG  = 16,
  localparam int RW   = $clog2(NREG),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_valid,
  input logic [RW-1:0]   disp_dst,
  input logic            full,
  input logic            conflict,
  input logic            wb_valid,
  input logic [RW-1:0]   wb_dst,
  input logic            iss_valid,
  input logic [CW-1:0]   cnt,
  input logic [NREG-1:0] rvalid
);

  logic acc;
  assign acc = disp_valid && !full && !conflict;

  p_accept_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !iss_valid) |=> cnt == $past(cnt) + CW'(1));

  p_issue_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !acc) |=> cnt == $past(cnt) - CW'(1));

  p_empty_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !iss_valid);

  p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !iss_valid) |=> full);

  p_wb_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_dst != '0 && !(acc && disp_dst == wb_dst)) |=> rvalid[$past(wb_dst)]);

  p_disp_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && disp_dst != '0) |=> !rvalid[$past(disp_dst)]);

  p_reg0_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid[0]);

endmodule

bind issue_shelf issue_shelf_chk #(.DEPTH(DEPTH), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dst(disp_dst),
  .full(full), .conflict(conflict), .wb_valid(wb_valid), .wb_dst(wb_dst),
  .iss_valid(iss_valid), .cnt(cnt), .rvalid(rvalid)
);

// File: tb/sim_issue_shelf.sv
`timescale 1ns/1ps
module sim_issue_shelf;
  localparam int D = 4, NR = 16, OW = 4, DW = 16, RW = 4;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic dv = 0, du1 = 0, du2 = 0, wv = 0;
  logic [OW-1:0] dop = 0;
  logic [RW-1:0] ddst = 0, ds1 = 0, ds2 = 0, wdst = 0;
  logic [DW-1:0] wd = 0;
  logic full, conflict, iv;
  logic [OW-1:0] iop;
  logic [RW-1:0] idst;
  logic [DW-1:0] ia, ib;

  issue_shelf #(.DEPTH(D), .NREG(NR), .OPW(OW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_op(dop), .disp_dst(ddst),
    .disp_src1(ds1), .disp_use1(du1), .disp_src2(ds2), .disp_use2(du2),
    .full(full), .conflict(conflict), .wb_valid(wv), .wb_dst(wdst), .wb_data(wd),
    .iss_valid(iv), .iss_op(iop), .iss_dst(idst), .iss_opa(ia), .iss_opb(ib));

  int checks = 0, fails = 0, mcnt = 0;
  logic [OW-1:0] q_op [D];
  logic [RW-1:0] q_dst [D], q_s1 [D], q_s2 [D];
  bit q_r1 [D], q_r2 [D];
  logic [DW-1:0] mrf [NR];
  bit mval [NR], infl [NR];
  bit x_iv, x_full, x_conf;
  int x_sel;

  function automatic bit mhit(logic [RW-1:0] s);
    return wv && wdst == s && s != 0;
  endfunction

  function automatic logic [DW-1:0] mread(logic [RW-1:0] s);
    if (s == 0) return '0;
    if (mhit(s)) return wd;
    return mrf[s];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic predict_and_check(string tag);
    bit rd;
    x_iv = 0; x_sel = 0; rd = 0;
    for (int i = mcnt - 1; i >= 0; i--)
      if ((q_r1[i] || mhit(q_s1[i])) && (q_r2[i] || mhit(q_s2[i]))) begin x_iv = 1; x_sel = i; end
    for (int i = 0; i < mcnt; i++)
      if (q_s1[i] == ddst || q_s2[i] == ddst) rd = 1;
    x_full = (mcnt == D);
    x_conf = dv && ddst != 0 && (rd || (!mval[ddst] && !mhit(ddst)));
    chk(tag, "full", 32'(full), 32'(x_full));
    chk(tag, "conflict", 32'(conflict), 32'(x_conf));
    chk(tag, "iss_valid", 32'(iv), 32'(x_iv));
    if (x_iv) begin
      chk(tag, "iss_op", 32'(iop), 32'(q_op[x_sel]));
      chk(tag, "iss_dst", 32'(idst), 32'(q_dst[x_sel]));
      chk(tag, "iss_opa", 32'(ia), 32'(mread(q_s1[x_sel])));
      chk(tag, "iss_opb", 32'(ib), 32'(mread(q_s2[x_sel])));
    end
  endtask

  task automatic model_step();
    bit acc;
    logic [RW-1:0] s1n, s2n;
    acc = dv && !x_full && !x_conf;
    if (x_iv) begin
      if (q_dst[x_sel] != 0) infl[q_dst[x_sel]] = 1;
      for (int i = x_sel; i < mcnt - 1; i++) begin
        q_op[i] = q_op[i+1]; q_dst[i] = q_dst[i+1];
        q_s1[i] = q_s1[i+1]; q_s2[i] = q_s2[i+1];
        q_r1[i] = q_r1[i+1]; q_r2[i] = q_r2[i+1];
      end
      mcnt--;
    end
    for (int i = 0; i < mcnt; i++) begin
      q_r1[i] = q_r1[i] | mhit(q_s1[i]);
      q_r2[i] = q_r2[i] | mhit(q_s2[i]);
    end
    if (acc) begin
      s1n = du1 ? ds1 : '0;
      s2n = du2 ? ds2 : '0;
      q_op[mcnt] = dop; q_dst[mcnt] = ddst; q_s1[mcnt] = s1n; q_s2[mcnt] = s2n;
      q_r1[mcnt] = (s1n == 0) || mval[s1n] || mhit(s1n);
      q_r2[mcnt] = (s2n == 0) || mval[s2n] || mhit(s2n);
      mcnt++;
    end
    if (wv && wdst != 0) begin mrf[wdst] = wd; mval[wdst] = 1; infl[wdst] = 0; end
    if (acc && ddst != 0) mval[ddst] = 0;
  endtask

  task automatic cyc(input bit v, input int op, input int dst, input int s1, input bit u1,
                     input int s2, input bit u2, input bit w, input int wr, input int wdat,
                     input string tag);
    @(negedge clk);
    dv = v; dop = OW'(op); ddst = RW'(dst); ds1 = RW'(s1); du1 = u1; ds2 = RW'(s2); du2 = u2;
    wv = w; wdst = RW'(wr); wd = DW'(wdat);
    #1;
    predict_and_check(tag);
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin mrf[i] = '0; mval[i] = 1; infl[i] = 0; end
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    idle("R12");
    cyc(1, 1, 1, 2, 1, 3, 1, 0, 0, 0, "R1");
    idle("R12");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 'h1234, "R5");
    cyc(1, 2, 2, 1, 1, 5, 0, 0, 0, 0, "R5");
    idle("R2");
    cyc(1, 3, 3, 0, 0, 0, 0, 0, 0, 0, "R6");
    cyc(1, 4, 4, 3, 1, 0, 0, 0, 0, 0, "R6");
    idle("R6");
    idle("R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 3, 'hBEEF, "R9");
    cyc(1, 5, 5, 2, 1, 0, 0, 0, 0, 0, "R10");
    cyc(1, 6, 2, 0, 0, 0, 0, 0, 0, 0, "R10");
    cyc(1, 6, 5, 0, 0, 0, 0, 0, 0, 0, "R10");
    cyc(1, 7, 8, 2, 1, 0, 0, 0, 0, 0, "R8");
    cyc(1, 8, 9, 2, 1, 0, 0, 0, 0, 0, "R8");
    cyc(1, 9, 10, 2, 1, 0, 0, 0, 0, 0, "R8");
    cyc(1, 10, 11, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 2, 'h0042, "R7");
    idle("R7");
    idle("R7");
    idle("R7");
    idle("R8");
    cyc(1, 11, 1, 1, 1, 1, 1, 0, 0, 0, "R11");
    idle("R11");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 'hFFFF, "R5");
    cyc(1, 12, 13, 0, 1, 0, 1, 0, 0, 0, "R5");
    idle("R2");
    cyc(1, 13, 12, 1, 1, 3, 1, 0, 0, 0, "R3");
    idle("R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 'h0077, "R3");
    idle("R4");

    for (int n = 0; n < 4000; n++) begin
      int pick;
      int st;
      pick = -1;
      if ($urandom % 3 != 0) begin
        st = int'($urandom % NR);
        for (int k = 0; k < NR; k++)
          if (pick < 0 && infl[(st + k) % NR]) pick = (st + k) % NR;
      end
      cyc(1'($urandom % 2), int'($urandom % 16), int'($urandom % 8), int'($urandom % 8),
          1'($urandom % 2), int'($urandom % 8), 1'($urandom % 2), pick >= 0,
          pick < 0 ? 0 : pick, int'($urandom % 65536), "R4 R7 R10");
    end
    for (int n = 0; n < 40; n++) begin
      int pick;
      pick = -1;
      for (int k = 0; k < NR; k++) if (pick < 0 && infl[k]) pick = k;
      cyc(0, 0, 0, 0, 0, 0, 0, pick >= 0, pick < 0 ? 0 : pick, n * 7 + 3, "R9");
    end

    summary();
    $finish;
  end
endmodule